// File: doc/BRIEF.md
# Clock Request Output Gating

This block decides, for six gateable differential reference-clock pairs and two graphics-clock pairs, whether each pair drives or is tri-stated. Two shared active-low request pins can be assigned to any of the six gateable pairs. The assignment, one bit per pair and per line, comes from configuration register bytes. A master enable bit per pair overrides everything. The two graphics pairs only have plain enables and ignore the request pins.

The request pins are asynchronous. Each one passes through a synchroniser clocked by the output clock. The enable registers load on the falling edge of that clock, so an enable only changes while the clock is low and a running clock never loses part of a high phase. The request pins have internal pull-downs, so a pin left unconnected reads as "run". The register that supplies the configuration bytes should reset all master and graphics enables to 1 and all binding bits to 0.

Top module: `refclk_req_gate`

## Requirements
- R1: A bound request line that is high (not requesting) forces its bound pairs off. The same line low lets them run, subject to their master enable. Line A's bindings are `cfg_auxa[7:4]` for outputs 7..4, `cfg_main[1]` for output 3 and `cfg_main[0]` for output 0. Line B's bindings are `cfg_reqb[7:3]` for outputs 7..3 and `cfg_reqb[0]` for output 0.
- R2: A master enable of 0 turns its pair off whatever the request pins do. The master enables are `cfg_main[7:2]`, one each for outputs 7, 6, 5, 4, 3 and 0. `oe_src[5:0]` maps to outputs 7, 6, 5, 4, 3 and 0 in that order, with 1 meaning drive.
- R3: A gateable pair bound to neither line follows its master enable alone. Request pin activity has no effect on it.
- R4: A pair bound to both lines runs only while both requests are asserted (both pins low).
- R5: `oe_gfx[1]` follows `cfg_auxa[2]` and `oe_gfx[0]` follows `cfg_auxa[1]`. Neither is ever affected by the request pins.
- R6: A request level present at a rising edge of `clk` reaches the enables at the falling edge that follows the SYNC_STAGES-th rising edge that samples it. A configuration change made before a falling edge takes effect at that falling edge.
- R7: Enables change only at falling edges of `clk`, so they are stable throughout every high phase.
- R8: While `rst_n` is low, every enable is 0. After release, the synchronisers start from "not requested".

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Output clock; enables follow its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_a_n | input | 1 | Request line A, active low, asynchronous |
| req_b_n | input | 1 | Request line B, active low, asynchronous |
| cfg_main | input | 8 | Master enables [7:2], line-A bindings of outputs 3 and 0 [1:0] |
| cfg_reqb | input | 8 | Line-B bindings: [7:3] outputs 7..3, [0] output 0, [2:1] unused |
| cfg_auxa | input | 8 | Line-A bindings of outputs 7..4 [7:4], graphics enables [2:1], [3] and [0] unused |
| oe_src | output | 6 | Drive enables for outputs 7, 6, 5, 4, 3, 0 |
| oe_gfx | output | 2 | Drive enables for the two graphics pairs |

## Verification
The bench targets the following cases:
- Pairs bound to both lines. A design that ORs the two requests would keep such a pair running with only one request asserted.
- Unbound pairs and the graphics pairs while the request pins toggle. Leaking the request into them would make them drop out.
- Single-cycle request pulses. These show whether the synchroniser depth is right; a stage too few or too many moves the enable one edge early or late.
- A check in every high phase that each enable equals the value loaded at the previous falling edge. A design that updates on the rising edge would change the enable mid-pulse.
- A reset asserted mid-run. A design that does not clear its synchronisers would restart gated pairs as "requested".

// File: rtl/refclk_req_gate.sv
module refclk_req_gate #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_a_n,
  input  logic       req_b_n,
  input  logic [7:0] cfg_main,
  input  logic [7:0] cfg_reqb,
  input  logic [7:0] cfg_auxa,
  output logic [5:0] oe_src,
  output logic [1:0] oe_gfx
);

  logic [SYNC_STAGES-1:0] sync_a, sync_b;
  logic                   ra_s, rb_s;
  logic [5:0]             master, bind_a, bind_b, run;
  logic                   unused_bits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_a <= '0;
      sync_b <= '0;
    end else begin
      sync_a <= {sync_a[SYNC_STAGES-2:0], ~req_a_n};
      sync_b <= {sync_b[SYNC_STAGES-2:0], ~req_b_n};
    end
  end

  assign ra_s   = sync_a[SYNC_STAGES-1];
  assign rb_s   = sync_b[SYNC_STAGES-1];

  assign master = cfg_main[7:2];
  assign bind_a = {cfg_auxa[7:4], cfg_main[1:0]};
  assign bind_b = {cfg_reqb[7:3], cfg_reqb[0]};
  assign run    = master & (~bind_a | {6{ra_s}}) & (~bind_b | {6{rb_s}});

  assign unused_bits = ^{cfg_reqb[2:1], cfg_auxa[3], cfg_auxa[0]};

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_src <= '0;
      oe_gfx <= '0;
    end else begin
      oe_src <= run;
      oe_gfx <= cfg_auxa[2:1];
    end
  end

  // R1
  line_a_gate_chk: assert property (@(negedge clk) disable iff (!rst_n)
    !ra_s |=> ((oe_src & $past(bind_a)) == 6'd0));

  // R1
  line_b_gate_chk: assert property (@(negedge clk) disable iff (!rst_n)
    !rb_s |=> ((oe_src & $past(bind_b)) == 6'd0));

  // R2
  master_off_chk: assert property (@(negedge clk) disable iff (!rst_n)
    (master != 6'h3f) |=> ((oe_src & ~$past(master)) == 6'd0));

  // R3
  unbound_follow_chk: assert property (@(negedge clk) disable iff (!rst_n)
    ((bind_a | bind_b) != 6'h3f) |=>
      (((oe_src ^ $past(master)) & ~$past(bind_a | bind_b)) == 6'd0));

  // R5
  gfx_plain_chk: assert property (@(negedge clk) disable iff (!rst_n)
    $changed(cfg_auxa[2:1]) |=> (oe_gfx == $past(cfg_auxa[2:1])));

  // R7
  always @(oe_src or oe_gfx) begin
    if (rst_n) begin
      low_phase_chk: assert (!clk) else $error("enable moved while clock high");
    end
  end

endmodule

// File: tb/refclk_req_gate_tb.sv
module refclk_req_gate_tb;
  localparam int CLK_PERIOD = 10;
  localparam int STAGES     = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_a_n = 1'b0;
  logic       req_b_n = 1'b0;
  logic [7:0] cfg_main = 8'hFC;
  logic [7:0] cfg_reqb = 8'h00;
  logic [7:0] cfg_auxa = 8'h06;
  logic [5:0] oe_src;
  logic [1:0] oe_gfx;

  int    checks = 0;
  int    errors = 0;
  string tag = "R8";
  bit    qa[$];
  bit    qb[$];
  logic [7:0] exp_q = 8'h00;

  always #(CLK_PERIOD/2) clk = ~clk;

  refclk_req_gate #(.SYNC_STAGES(STAGES)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_a_n(req_a_n), .req_b_n(req_b_n),
    .cfg_main(cfg_main), .cfg_reqb(cfg_reqb), .cfg_auxa(cfg_auxa),
    .oe_src(oe_src), .oe_gfx(oe_gfx)
  );

  function automatic logic [7:0] model();
    logic [7:0] r;
    bit ra, rb, m, ba, bb, go;
    ra = (qa.size() >= STAGES) ? qa[qa.size()-STAGES] : 1'b0;
    rb = (qb.size() >= STAGES) ? qb[qb.size()-STAGES] : 1'b0;
    r = '0;
    for (int k = 0; k < 6; k++) begin
      m  = cfg_main[k+2];
      ba = (k >= 2) ? cfg_auxa[k+2] : cfg_main[k];
      bb = (k >= 1) ? cfg_reqb[k+2] : cfg_reqb[0];
      go = m;
      if (ba && !ra) go = 1'b0;
      if (bb && !rb) go = 1'b0;
      r[k] = go;
    end
    r[7] = cfg_auxa[2];
    r[6] = cfg_auxa[1];
    return r;
  endfunction

  task automatic compare(input logic [7:0] expv, input string t);
    checks++;
    if ({oe_gfx, oe_src} !== expv) begin
      errors++;
      $display("FAIL %s: enables=%b expected %b at %0t", t, {oe_gfx, oe_src}, expv, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      qa.delete();
      qb.delete();
    end else begin
      qa.push_back(!req_a_n);
      qb.push_back(!req_b_n);
    end
  end

  always @(negedge clk) begin
    #1;
    exp_q = rst_n ? model() : 8'h00;
    compare(exp_q, tag);
  end

  always @(posedge clk) begin
    #2;
    compare(rst_n ? exp_q : 8'h00, "R7");
  end

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: run did not finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tag = "R8";
    cyc(4);
    rst_n = 1'b1;

    tag = "R3";
    cyc(3);
    req_a_n = 1'b1; cyc(3);
    req_b_n = 1'b1; cyc(3);
    req_a_n = 1'b0; req_b_n = 1'b0; cyc(3);

    tag = "R2";
    cfg_main = 8'hAA; req_a_n = 1'b1; cyc(3);
    req_a_n = 1'b0; cyc(4);
    cfg_main = 8'h02; cyc(2);
    req_a_n = 1'b1; req_b_n = 1'b1; cyc(4);
    req_a_n = 1'b0; req_b_n = 1'b0;
    cfg_main = 8'hFC; cyc(4);

    tag = "R1";
    cfg_auxa = 8'h96; cfg_reqb = 8'h41; cyc(3);
    req_a_n = 1'b1; cyc(4);
    req_b_n = 1'b1; cyc(4);
    req_a_n = 1'b0; cyc(4);
    req_b_n = 1'b0; cyc(4);
    cfg_main = 8'hFD; req_a_n = 1'b1; cyc(4);
    cfg_main = 8'hFC; req_a_n = 1'b0; cyc(4);

    tag = "R6";
    req_a_n = 1'b1; cyc(1);
    req_a_n = 1'b0; cyc(4);
    req_b_n = 1'b1; cyc(1);
    req_b_n = 1'b0; cyc(4);
    req_a_n = 1'b1; cyc(2);
    req_a_n = 1'b0; cyc(4);

    tag = "R4";
    cfg_auxa = 8'h26; cfg_reqb = 8'h20; cyc(3);
    req_a_n = 1'b1; req_b_n = 1'b0; cyc(4);
    req_a_n = 1'b0; req_b_n = 1'b1; cyc(4);
    req_a_n = 1'b1; req_b_n = 1'b1; cyc(4);
    req_a_n = 1'b0; req_b_n = 1'b0; cyc(4);

    tag = "R5";
    cfg_auxa = 8'h02; cfg_reqb = 8'h00; cyc(3);
    cfg_auxa = 8'h04; req_a_n = 1'b1; req_b_n = 1'b1; cyc(3);
    cfg_auxa = 8'h00; cyc(3);
    cfg_auxa = 8'h06; req_a_n = 1'b0; req_b_n = 1'b0; cyc(3);

    tag = "R8";
    cfg_auxa = 8'h96; cfg_reqb = 8'h41; cyc(4);
    rst_n = 1'b0; cyc(3);
    rst_n = 1'b1; cyc(5);
    req_b_n = 1'b1; cyc(4);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule